// File: doc/BRIEF.md
# Reconfiguration Bitstream Sink Controller

This block is the control side of a partial reconfiguration engine. It takes in a configuration bitstream as a streaming sink. The stream uses a valid/ready handshake with backpressure and zero read latency. A rising edge on the start input opens a session. The block then raises a freeze output for as long as the session lasts. It paces its ready output by a programmable clock-to-data ratio and counts accepted words against a static expected length.

The first word of the stream is compared with a static expected header. Every word except the last feeds a running CRC-32. The last word carries the CRC value that the block expects to see. The result of the session appears on a 3-bit status output.

Some errors are found while the session is still running: a header mismatch, or a start request that is still held when the last word arrives. These errors end the session at once. A CRC mismatch is different. It is only reported after the session ends, and only when no other error occurred.

Top module: `cfg_stream_sink`

## Requirements
- R1: After reset, freezeOut is 0, statusOut is 3'b000 (idle) and inReady is 0.
- R2: On the first clock edge where startReq is high after having been low, the block takes one cycle to arm. In that cycle freezeOut becomes 1 and statusOut is cleared to 3'b000. On the next edge statusOut becomes 3'b001 (busy) and the block begins accepting words.
- R3: Two cases never start a second session: a startReq held high for several cycles, and a new startReq edge while freezeOut is high. After the session ends, freezeOut stays 0 until startReq goes low and then rises again.
- R4: While accepting, inReady is high for one cycle and then low for cfgRatio-1 cycles, repeating. When cfgRatio is 0 or 1, inReady stays high.
- R5: A word is consumed only in a cycle where inValid and inReady are both 1. Words presented while inReady is 0 are not counted.
- R6: After word number expWords (counting from 1) is accepted, inReady stays 0 until the session ends. Dummy words presented with inValid high in that period are ignored.
- R7: The cycle after the last word is accepted, freezeOut falls. If the CRC matches, statusOut becomes 3'b101 (success) on that same edge.
- R8: If the last word differs from the CRC of the earlier words, statusOut becomes 3'b011 (CRC error), on the same edge where freezeOut falls after the session.
- R9: If word 0 differs from expHeader, then on the edge that accepts it statusOut becomes 3'b100 (incompatible) and freezeOut falls. No further words are taken.
- R10: If startReq is high on the edge that accepts the last word, statusOut becomes 3'b010 (reconfiguration error) and freezeOut falls on that edge. No CRC result is reported.
- R11: The CRC is CRC-32 in reflected form. It uses polynomial 0xEDB88320 and starts from all ones. Each word is fed in LSB first, and the final value is inverted. It runs over words 0 to expWords-2, and its result is compared with bits [31:0] of the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Session start request (rising edge) |
| cfgRatio | input | RATIO_W | Clock-to-data ratio (0 and 1 mean no throttling) |
| expWords | input | CNT_W | Total words in the stream, including header and CRC (at least 2) |
| expHeader | input | DATA_W | Expected value of word 0 |
| inData | input | DATA_W | Stream data |
| inValid | input | 1 | Stream data valid |
| inReady | output | 1 | Sink ready, throttled |
| freezeOut | output | 1 | High while a session runs |
| statusOut | output | 3 | Session status code |

## Verification
The assertions take three things for granted. First, cfgRatio, expWords and expHeader are held steady for the whole of a session. Second, expWords is at least 2. Third, startReq is low before each session is opened. The stimulus sets the ratio and length before it pulses the start input, and it never changes them until freezeOut has fallen. Between sessions it returns startReq low. It releases startReq before the last word, except in the vector that deliberately provokes the reconfiguration error.

// File: rtl/cfg_sink_pkg.sv
package cfg_sink_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'b000,
    ST_BUSY     = 3'b001,
    ST_PRERR    = 3'b010,
    ST_CRCERR   = 3'b011,
    ST_INCOMPAT = 3'b100,
    ST_OK       = 3'b101
  } sinkStatus_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ARM,
    PH_RUN,
    PH_FIN
  } sinkPhase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic run;
  } ctlStrobe_t;

  // flags from datapath to control
  typedef struct packed {
    logic take;
    logic isFirst;
    logic isLast;
    logic hdrMatch;
    logic crcMatch;
  } dpFlags_t;

  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

endpackage

// File: rtl/cfg_sink_dp.sv
module cfg_sink_dp
  import cfg_sink_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobe_t         ctl,
  input  logic [RATIO_W-1:0] cfgRatio,
  input  logic [CNT_W-1:0]   expWords,
  input  logic [DATA_W-1:0]  expHeader,
  input  logic [DATA_W-1:0]  inData,
  input  logic               inValid,
  output logic               inReady,
  output dpFlags_t           flags
);

  logic [RATIO_W-1:0] phase;
  logic [RATIO_W-1:0] phaseTop;
  logic [CNT_W-1:0]   wordCnt;
  logic [CRC_W-1:0]   crcReg;
  logic [CRC_W-1:0]   crcNext;
  logic               take;

  // ratio 0 and 1 both mean one word per cycle
  assign phaseTop = (cfgRatio <= RATIO_W'(1)) ? '0 : cfgRatio - RATIO_W'(1);

  assign inReady = ctl.run && (phase == '0);
  assign take    = inReady && inValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (ctl.clear) begin
      phase <= '0;
    end else if (ctl.run) begin
      phase <= (phase == phaseTop) ? '0 : phase + RATIO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wordCnt <= '0;
    end else if (ctl.clear) begin
      wordCnt <= '0;
    end else if (take) begin
      wordCnt <= wordCnt + CNT_W'(1);
    end
  end

  // reflected CRC-32, LSB of the word first
  always_comb begin
    crcNext = crcReg;
    for (int b = 0; b < DATA_W; b++) begin
      if (crcNext[0] ^ inData[b]) crcNext = (crcNext >> 1) ^ CRC_POLY;
      else                        crcNext = crcNext >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcReg <= '1;
    end else if (ctl.clear) begin
      crcReg <= '1;
    end else if (take && !flags.isLast) begin
      crcReg <= crcNext;
    end
  end

  assign flags.take     = take;
  assign flags.isFirst  = (wordCnt == '0);
  assign flags.isLast   = (wordCnt == expWords - CNT_W'(1));
  assign flags.hdrMatch = (inData == expHeader);
  assign flags.crcMatch = (~crcReg == inData[CRC_W-1:0]);

endmodule

// File: rtl/cfg_sink_ctrl.sv
module cfg_sink_ctrl
  import cfg_sink_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startReq,
  input  dpFlags_t    flags,
  output ctlStrobe_t  ctl,
  output logic        freezeOut,
  output logic [2:0]  statusOut
);

  sinkPhase_e  phase;
  sinkStatus_e status;
  logic        startPrev;
  logic        startEdge;
  logic        crcOkQ;

  assign startEdge = startReq && !startPrev;
  assign ctl.clear = (phase == PH_IDLE);
  assign ctl.run   = (phase == PH_RUN);
  assign statusOut = status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      startPrev <= 1'b0;
      phase     <= PH_IDLE;
      status    <= ST_IDLE;
      freezeOut <= 1'b0;
      crcOkQ    <= 1'b0;
    end else begin
      startPrev <= startReq;
      case (phase)
        PH_IDLE: begin
          if (startEdge) begin
            phase     <= PH_ARM;
            freezeOut <= 1'b1;
            status    <= ST_IDLE;
          end
        end
        PH_ARM: begin
          status <= ST_BUSY;
          phase  <= PH_RUN;
        end
        PH_RUN: begin
          if (flags.take) begin
            if (flags.isFirst && !flags.hdrMatch) begin
              status    <= ST_INCOMPAT;
              freezeOut <= 1'b0;
              phase     <= PH_IDLE;
            end else if (flags.isLast) begin
              if (startReq) begin
                status    <= ST_PRERR;
                freezeOut <= 1'b0;
                phase     <= PH_IDLE;
              end else begin
                crcOkQ <= flags.crcMatch;
                phase  <= PH_FIN;
              end
            end
          end
        end
        PH_FIN: begin
          status    <= crcOkQ ? ST_OK : ST_CRCERR;
          freezeOut <= 1'b0;
          phase     <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_stream_sink.sv
module cfg_stream_sink
  import cfg_sink_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startReq,
  input  logic [RATIO_W-1:0] cfgRatio,
  input  logic [CNT_W-1:0]   expWords,
  input  logic [DATA_W-1:0]  expHeader,
  input  logic [DATA_W-1:0]  inData,
  input  logic               inValid,
  output logic               inReady,
  output logic               freezeOut,
  output logic [2:0]         statusOut
);

  ctlStrobe_t ctl;
  dpFlags_t   flags;

  cfg_sink_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startReq  (startReq),
    .flags     (flags),
    .ctl       (ctl),
    .freezeOut (freezeOut),
    .statusOut (statusOut)
  );

  cfg_sink_dp #(
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .RATIO_W (RATIO_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .cfgRatio  (cfgRatio),
    .expWords  (expWords),
    .expHeader (expHeader),
    .inData    (inData),
    .inValid   (inValid),
    .inReady   (inReady),
    .flags     (flags)
  );

endmodule

// File: rtl/cfg_sink_chk.sv
module cfg_sink_chk #(
  parameter int RATIO_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [RATIO_W-1:0] cfgRatio,
  input logic               inReady,
  input logic               freezeOut,
  input logic [2:0]         statusOut
);

  // R1: the sink is never ready outside a session
  a_r1_ready_in_session: assert property (@(posedge clk) disable iff (!rst_n)
    inReady |-> freezeOut);

  // R2: a session opens with the status cleared to idle
  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freezeOut) |-> statusOut == 3'b000);

  // R3: once armed, the status never returns to idle inside the session
  a_r3_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (freezeOut && $past(freezeOut)) |-> statusOut != 3'b000);

  // R4: with a ratio above one, a ready cycle is followed by a low one
  a_r4_throttle: assert property (@(posedge clk) disable iff (!rst_n)
    (inReady && cfgRatio > RATIO_W'(1)) |=> !inReady);

  // R7: freeze falls together with a final result code
  a_r7_final_code: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(freezeOut) |-> (statusOut == 3'b010 || statusOut == 3'b011 ||
                          statusOut == 3'b100 || statusOut == 3'b101));

  // R2: busy is reported only while frozen
  a_r2_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (statusOut == 3'b001) |-> freezeOut);

endmodule

bind cfg_stream_sink cfg_sink_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfgRatio  (cfgRatio),
  .inReady   (inReady),
  .freezeOut (freezeOut),
  .statusOut (statusOut)
);

// File: tb/cfg_stream_sink_tb.sv
module cfg_stream_sink_tb;

  localparam int DATA_W  = 32;
  localparam int CNT_W   = 16;
  localparam int RATIO_W = 4;
  localparam logic [31:0] HDR = 32'hC0DE_5A17;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               startReq = 1'b0;
  logic [RATIO_W-1:0] cfgRatio = '0;
  logic [CNT_W-1:0]   expWords = '0;
  logic [DATA_W-1:0]  expHeader = HDR;
  logic [DATA_W-1:0]  inData = '0;
  logic               inValid = 1'b0;
  logic               inReady;
  logic               freezeOut;
  logic [2:0]         statusOut;

  int nChecks = 0;
  int nFails  = 0;
  bit ended   = 1'b0;

  always #5 clk = ~clk;

  cfg_stream_sink #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RATIO_W(RATIO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .cfgRatio(cfgRatio),
    .expWords(expWords), .expHeader(expHeader), .inData(inData),
    .inValid(inValid), .inReady(inReady), .freezeOut(freezeOut),
    .statusOut(statusOut)
  );

  // vector: {ratio, words, hdrBad, crcBad, holdStart, midStart, expected status}
  localparam int NV = 7;
  localparam logic [18:0] VEC [NV] = '{
    {4'd1, 8'd6, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101},
    {4'd3, 8'd5, 1'b0, 1'b0, 1'b0, 1'b1, 3'b101},
    {4'd2, 8'd4, 1'b0, 1'b1, 1'b0, 1'b0, 3'b011},
    {4'd4, 8'd6, 1'b1, 1'b0, 1'b0, 1'b0, 3'b100},
    {4'd1, 8'd5, 1'b0, 1'b0, 1'b1, 1'b0, 3'b010},
    {4'd0, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101},
    {4'd5, 8'd8, 1'b0, 1'b1, 1'b0, 1'b1, 3'b011}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crcWord(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int b = 0; b < 32; b++)
      r = (r[0] ^ d[b]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic finishRun();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic runSession(input int ratio, input int n, input bit hdrBad,
                            input bit crcBad, input bit holdStart,
                            input bit midStart, input logic [2:0] expSt);
    logic [31:0] w [16];
    logic [31:0] c = 32'hFFFF_FFFF;
    int idx = 0;
    int cyc = 0;
    int lastRdy = -1;
    bit gapChecked = 1'b0;
    int eff = (ratio <= 1) ? 1 : ratio;
    for (int i = 0; i < n - 1; i++) begin
      w[i] = (i == 0) ? (hdrBad ? HDR ^ 32'h1 : HDR) : (32'h9E37_79B9 * i) ^ (ratio << 8);
      c = crcWord(c, w[i]);
    end
    w[n-1] = ~c ^ (crcBad ? 32'h0000_0100 : 32'h0);

    @(negedge clk);
    cfgRatio = RATIO_W'(ratio);
    expWords = CNT_W'(n);
    startReq = 1'b1;
    @(negedge clk);
    check(freezeOut == 1'b1 && statusOut == 3'b000, "R2 arm", {freezeOut, statusOut}, 4'b1000);
    if (!holdStart) startReq = 1'b0;
    @(negedge clk);
    check(statusOut == 3'b001, "R2 busy", statusOut, 3'b001);

    while (idx < n) begin
      bit rdy;
      bit vld = (cyc % 3) != 2;
      inData  = w[idx];
      inValid = vld;
      if (midStart && idx == 2) startReq = 1'b1;
      if (midStart && idx == 3) startReq = 1'b0;
      rdy = inReady;
      if (rdy) begin
        if (lastRdy >= 0 && !gapChecked) begin
          check((cyc - lastRdy) == eff, "R4 ready spacing", cyc - lastRdy, eff);
          gapChecked = 1'b1;
        end
        lastRdy = cyc;
      end
      @(negedge clk);
      cyc++;
      if (rdy && vld) begin
        if (hdrBad && idx == 0) break;
        idx++;
      end
    end

    if (hdrBad) begin
      check(freezeOut == 1'b0 && statusOut == 3'b100, "R9 header mismatch",
            {freezeOut, statusOut}, {1'b0, expSt});
      inValid = 1'b1;
      @(negedge clk);
      check(inReady == 1'b0 && statusOut == 3'b100, "R9 no further words",
            {inReady, statusOut}, 4'b0100);
    end else if (holdStart) begin
      check(freezeOut == 1'b0 && statusOut == 3'b010, "R10 start held at last word",
            {freezeOut, statusOut}, {1'b0, expSt});
    end else begin
      check(inReady == 1'b0 && freezeOut == 1'b1 && statusOut == 3'b001,
            "R6 ready low after last word", {inReady, freezeOut, statusOut}, 5'b01001);
      inData  = 32'hDEAD_BEEF;
      inValid = 1'b1;
      @(negedge clk);
      check(freezeOut == 1'b0 && statusOut == expSt,
            (expSt == 3'b101) ? "R7 success with R11 crc" : "R8 crc error",
            {freezeOut, statusOut}, {1'b0, expSt});
      check(inReady == 1'b0, "R6 dummy ignored", inReady, 0);
    end

    @(negedge clk);
    inValid  = 1'b0;
    startReq = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(freezeOut == 1'b0 && statusOut == expSt, "R3 no second session",
          {freezeOut, statusOut}, {1'b0, expSt});
  endtask

  initial begin
    #2_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(freezeOut == 1'b0 && statusOut == 3'b000 && inReady == 1'b0, "R1 reset",
          {inReady, freezeOut, statusOut}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [18:0] e = VEC[v];
      runSession(int'(e[18:15]), int'(e[14:7]), e[6], e[5], e[4], e[3], e[2:0]);
    end

    // R5: ratio 1, valid held low for several cycles while ready is high
    @(negedge clk);
    cfgRatio = RATIO_W'(1);
    expWords = CNT_W'(2);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    @(negedge clk);
    inData = HDR;
    repeat (4) @(negedge clk);
    check(freezeOut == 1'b1 && statusOut == 3'b001 && inReady == 1'b1,
          "R5 no consumption without valid", {inReady, freezeOut, statusOut}, 5'b11001);

    // reset in mid-session returns to idle
    rst_n = 1'b0;
    @(negedge clk);
    check(freezeOut == 1'b0 && statusOut == 3'b000 && inReady == 1'b0,
          "R1 reset mid-session", {inReady, freezeOut, statusOut}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    runSession(2, 3, 1'b0, 1'b0, 1'b0, 1'b0, 3'b101);
    finishRun();
  end

endmodule